// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset cause of a small controller into one chip-level reset. The causes are a power-on pulse, an active-low external reset pin, a watchdog expiry and a brown-out detect. Once the last cause has gone away, the reset is held for two start-up delays. The first delay counts ticks of a slow internal clock and lets the supply settle. The second counts ticks of the main oscillator and lets it stabilise. The reset is held by a set/clear latch: any cause sets it, and only the end of the delay chain clears it. A new cause arriving while a delay is running sends the chain back to its first stage.

Two status bits, time-out (TO) and power-down (PD), record the last reset or wake-up so that software can tell these cases apart:
- a cold start;
- a brown-out;
- a watchdog expiry while running;
- a watchdog expiry while asleep;
- a pin reset while running;
- a pin reset while asleep.

The external pin passes through a filter that ignores short pulses. Both clocks reach the block as single-cycle enable strobes in the system clock domain. Each delay stage can be removed by a parameter.

Top module: `rst_seq`

## Requirements
- R1: After the synchronous `rst`, `chip_reset` is 0 and `flag_to` = 1, `flag_pd` = 1.
- R2: A `por_pulse` sets `chip_reset` on the next clock and sets `flag_to` = 1, `flag_pd` = 1.
- R3: With both stages enabled, `chip_reset` is released after 2^PWRT_BITS `lf_tick` strobes followed by 2^OST_BITS `osc_tick` strobes. The count starts at the first clock that sees no active cause. With every strobe high, the one-cycle event pulse plus the two delays keep `chip_reset` high for 1 + 2048 + 1024 = 3073 cycles.
- R4: With both stages disabled by parameter, `chip_reset` is released one clock after the cause goes away, so a one-cycle pulse gives a reset 1 cycle wide.
- R5: A new cause during either delay stage restarts the sequence from the first stage. The reset then lasts the full R3 length counted from the new cause.
- R6: `ext_rst_n` causes a reset only after it has been low for FILT_LEN (default 4) consecutive `lf_tick` strobes. A shorter low pulse leaves `chip_reset` at 0.
- R7: A filtered pin reset while `sleeping` = 0 leaves TO/PD unchanged. While `sleeping` = 1 it gives TO = 1, PD = 0.
- R8: `wdt_timeout` with `sleeping` = 0 resets the chip and gives TO = 0, PD = 1.
- R9: `wdt_timeout` with `sleeping` = 1 is a wake-up. It does not assert `chip_reset` and gives TO = 0, PD = 0.
- R10: `bor_detect` resets the chip and gives TO = 1, PD = 1 when `bor_cfg_en` or `bor_sw_en` is 1. With both at 0 it changes neither the reset nor the flags.
- R11: `clr_wdt` gives TO = 1, PD = 1 and `sleep_enter` gives TO = 1, PD = 0. Flag updates take this priority: power-on, brown-out, watchdog, pin, clear-watchdog, sleep-entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high initialisation |
| lf_tick | input | 1 | Enable strobe of the low-frequency clock |
| osc_tick | input | 1 | Enable strobe of the main oscillator |
| por_pulse | input | 1 | Power-on detect pulse |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| bor_detect | input | 1 | Brown-out detect |
| bor_cfg_en | input | 1 | Brown-out enable, configuration bit |
| bor_sw_en | input | 1 | Brown-out enable, software bit |
| sleeping | input | 1 | Device is in sleep |
| clr_wdt | input | 1 | Clear-watchdog instruction pulse |
| sleep_enter | input | 1 | Sleep-entry instruction pulse |
| chip_reset | output | 1 | Chip-level reset, active high |
| flag_to | output | 1 | Time-out status bit |
| flag_pd | output | 1 | Power-down status bit |

## Verification
The bench drives each cause on its own: a power-on pulse, a watchdog expiry both while running and while asleep, a filtered pin reset in both sleep states, and a brown-out through each enable path. It also drives a brown-out with both enables off. Before each event the flags are first preset to a different value, so that an event which leaves them alone can be told apart from one that sets them. Reset widths are counted cycle by cycle on a default instance and on an instance with both stages removed, which separates the full delay chain from the bypass. Extra causes injected during the first stage and during the second stage show whether the sequence truly restarts. A pin pulse one tick too short tests the filter threshold.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_PWRT = 2'd2,
    ST_OST  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic to;
    logic pd;
  } stat_flags_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_n,
  output logic active
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [CW-1:0] low_cnt;

  // Any high sample restarts the run of consecutive low ticks.
  always_ff @(posedge clk) begin
    if (rst || pin_n) begin
      low_cnt <= '0;
    end else if (tick && low_cnt != FULL) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign active = (low_cnt == FULL);
endmodule

// File: rtl/rst_stage_timer.sv
module rst_stage_timer #(
  parameter int BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam logic [BITS-1:0] LAST = {BITS{1'b1}};

  logic [BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Done on the tick that completes 2^BITS counted ticks.
  assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/rst_status_flags.sv
module rst_status_flags
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic por_evt,
  input  logic bor_evt,
  input  logic wdt_evt,
  input  logic pin_evt,
  input  logic sleeping,
  input  logic clr_wdt,
  input  logic sleep_enter,
  output logic flag_to,
  output logic flag_pd
);
  stat_flags_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (por_evt || bor_evt) begin
      nxt = '{to: 1'b1, pd: 1'b1};
    end else if (wdt_evt) begin
      nxt = '{to: 1'b0, pd: !sleeping};
    end else if (pin_evt) begin
      if (sleeping) nxt = '{to: 1'b1, pd: 1'b0};
    end else if (clr_wdt) begin
      nxt = '{to: 1'b1, pd: 1'b1};
    end else if (sleep_enter) begin
      nxt = '{to: 1'b1, pd: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '{to: 1'b1, pd: 1'b1};
    else     cur <= nxt;
  end

  assign flag_to = cur.to;
  assign flag_pd = cur.pd;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int PWRT_BITS = 11,
  parameter int OST_BITS  = 10,
  parameter bit PWRT_EN   = 1'b1,
  parameter bit OST_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lf_tick,
  input  logic osc_tick,
  input  logic por_pulse,
  input  logic ext_rst_n,
  input  logic wdt_timeout,
  input  logic bor_detect,
  input  logic bor_cfg_en,
  input  logic bor_sw_en,
  input  logic sleeping,
  input  logic clr_wdt,
  input  logic sleep_enter,
  output logic chip_reset,
  output logic flag_to,
  output logic flag_pd
);
  seq_state_t state;
  logic       hold_latch;
  logic       pin_active, pin_q, pin_evt;
  logic       bor_hit, wdt_run, src_any;
  logic       pwrt_done, ost_done;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .tick(lf_tick), .pin_n(ext_rst_n), .active(pin_active)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_active;
  end

  assign pin_evt = pin_active && !pin_q;
  assign bor_hit = bor_detect && (bor_cfg_en || bor_sw_en);
  assign wdt_run = wdt_timeout && !sleeping;
  assign src_any = por_pulse || bor_hit || wdt_run || pin_active;

  generate
    if (PWRT_EN) begin : g_pwrt
      rst_stage_timer #(.BITS(PWRT_BITS)) u_pwrt (
        .clk(clk), .rst(rst), .clear(src_any || state != ST_PWRT),
        .run(state == ST_PWRT), .tick(lf_tick), .done(pwrt_done)
      );
    end else begin : g_no_pwrt
      assign pwrt_done = 1'b0;
    end
    if (OST_EN) begin : g_ost
      rst_stage_timer #(.BITS(OST_BITS)) u_ost (
        .clk(clk), .rst(rst), .clear(src_any || state != ST_OST),
        .run(state == ST_OST), .tick(osc_tick), .done(ost_done)
      );
    end else begin : g_no_ost
      assign ost_done = 1'b0;
    end
  endgenerate

  // Set/clear latch: any cause sets it, end of the delay chain clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      hold_latch <= 1'b0;
    end else if (src_any) begin
      state      <= ST_HOLD;
      hold_latch <= 1'b1;
    end else begin
      case (state)
        ST_HOLD: begin
          if (PWRT_EN) begin
            state <= ST_PWRT;
          end else if (OST_EN) begin
            state <= ST_OST;
          end else begin
            state      <= ST_RUN;
            hold_latch <= 1'b0;
          end
        end
        ST_PWRT: begin
          if (pwrt_done) begin
            if (OST_EN) begin
              state <= ST_OST;
            end else begin
              state      <= ST_RUN;
              hold_latch <= 1'b0;
            end
          end
        end
        ST_OST: begin
          if (ost_done) begin
            state      <= ST_RUN;
            hold_latch <= 1'b0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign chip_reset = hold_latch;

  rst_status_flags u_flags (
    .clk(clk), .rst(rst), .por_evt(por_pulse), .bor_evt(bor_hit),
    .wdt_evt(wdt_timeout), .pin_evt(pin_evt), .sleeping(sleeping),
    .clr_wdt(clr_wdt), .sleep_enter(sleep_enter),
    .flag_to(flag_to), .flag_pd(flag_pd)
  );
endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
  input logic clk,
  input logic rst,
  input logic por_pulse,
  input logic ext_rst_n,
  input logic wdt_timeout,
  input logic bor_detect,
  input logic bor_cfg_en,
  input logic bor_sw_en,
  input logic sleeping,
  input logic clr_wdt,
  input logic sleep_enter,
  input logic chip_reset,
  input logic flag_to,
  input logic flag_pd
);
  logic bor_on;
  assign bor_on = bor_detect && (bor_cfg_en || bor_sw_en);

  assert_por_R2: assert property (@(posedge clk) disable iff (rst)
    por_pulse |=> (chip_reset && flag_to && flag_pd));

  assert_wdt_run_R8: assert property (@(posedge clk) disable iff (rst)
    (wdt_timeout && !sleeping && !por_pulse && !bor_on) |=>
      (chip_reset && !flag_to && flag_pd));

  assert_wdt_wake_R9: assert property (@(posedge clk) disable iff (rst)
    (wdt_timeout && sleeping && !por_pulse && !bor_on) |=> (!flag_to && !flag_pd));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!por_pulse && !bor_on && !wdt_timeout && !clr_wdt && !sleep_enter && !sleeping)
      |=> $stable({flag_to, flag_pd}));

  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_reset) |-> $past(por_pulse || bor_on || (wdt_timeout && !sleeping) || !ext_rst_n));

  assert_clr_wdt_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt && !por_pulse && !bor_on && !wdt_timeout && !sleeping) |=> (flag_to && flag_pd));

  assert_bor_R10: assert property (@(posedge clk) disable iff (rst)
    bor_on |=> (chip_reset && flag_to && flag_pd));
endmodule

bind rst_seq rst_seq_checker u_chk (
  .clk(clk), .rst(rst), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n),
  .wdt_timeout(wdt_timeout), .bor_detect(bor_detect), .bor_cfg_en(bor_cfg_en),
  .bor_sw_en(bor_sw_en), .sleeping(sleeping), .clr_wdt(clr_wdt),
  .sleep_enter(sleep_enter), .chip_reset(chip_reset), .flag_to(flag_to),
  .flag_pd(flag_pd)
);

// File: tb/rst_seq_bench.sv
module rst_seq_bench;
  localparam int FULL_LEN = 1 + 2048 + 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lf_tick = 1'b1, osc_tick = 1'b1;
  logic por_pulse = 1'b0, ext_rst_n = 1'b1, wdt_timeout = 1'b0;
  logic bor_detect = 1'b0, bor_cfg_en = 1'b0, bor_sw_en = 1'b0;
  logic sleeping = 1'b0, clr_wdt = 1'b0, sleep_enter = 1'b0;
  logic chip_reset, flag_to, flag_pd;
  logic byp_reset, byp_to, byp_pd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rst_seq u_rst_seq (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .osc_tick(osc_tick),
    .por_pulse(por_pulse), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
    .bor_detect(bor_detect), .bor_cfg_en(bor_cfg_en), .bor_sw_en(bor_sw_en),
    .sleeping(sleeping), .clr_wdt(clr_wdt), .sleep_enter(sleep_enter),
    .chip_reset(chip_reset), .flag_to(flag_to), .flag_pd(flag_pd)
  );

  rst_seq #(.PWRT_EN(1'b0), .OST_EN(1'b0)) u_rst_seq_bypass (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .osc_tick(osc_tick),
    .por_pulse(por_pulse), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
    .bor_detect(bor_detect), .bor_cfg_en(bor_cfg_en), .bor_sw_en(bor_sw_en),
    .sleeping(sleeping), .clr_wdt(clr_wdt), .sleep_enter(sleep_enter),
    .chip_reset(byp_reset), .flag_to(byp_to), .flag_pd(byp_pd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int to_e, input int pd_e);
    chk({req, " TO"}, int'(flag_to), to_e);
    chk({req, " PD"}, int'(flag_pd), pd_e);
  endtask

  // Called on the negedge right after a one-cycle event was removed.
  task automatic measure(output int n_main, output int n_byp);
    n_main = 0;
    n_byp  = 0;
    for (int i = 0; i < 10000; i++) begin
      if (!chip_reset && !byp_reset) break;
      if (chip_reset) n_main++;
      if (byp_reset)  n_byp++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_por();
    @(negedge clk) por_pulse = 1'b1;
    @(negedge clk) por_pulse = 1'b0;
  endtask

  task automatic pulse_sleep_enter();
    @(negedge clk) sleep_enter = 1'b1;
    @(negedge clk) sleep_enter = 1'b0;
  endtask

  task automatic pulse_clr_wdt();
    @(negedge clk) clr_wdt = 1'b1;
    @(negedge clk) clr_wdt = 1'b0;
  endtask

  task automatic quiet_reset(input string req, input int cycles);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (chip_reset) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 chip_reset", int'(chip_reset), 0);
    chk_flags("R1", 1, 1);
  endtask

  task automatic t_por();
    int nm, nb;
    pulse_sleep_enter();
    chk_flags("R11 sleep_enter", 1, 0);
    pulse_por();
    chk("R2 reset set", int'(chip_reset), 1);
    chk_flags("R2", 1, 1);
    measure(nm, nb);
    chk("R3 full length", nm, FULL_LEN);
    chk("R4 bypass length", nb, 1);
  endtask

  task automatic t_restart(input int wait_cycles, input string req);
    int nm, nb;
    pulse_por();
    repeat (wait_cycles) @(negedge clk);
    chk({req, " still held"}, int'(chip_reset), 1);
    pulse_por();
    measure(nm, nb);
    chk({req, " length"}, nm, FULL_LEN);
  endtask

  task automatic t_clr_wdt();
    pulse_sleep_enter();
    pulse_clr_wdt();
    chk_flags("R11 clr_wdt", 1, 1);
  endtask

  task automatic t_wdt_run();
    int nm, nb;
    @(negedge clk) wdt_timeout = 1'b1;
    @(negedge clk) wdt_timeout = 1'b0;
    chk("R8 reset set", int'(chip_reset), 1);
    chk_flags("R8", 0, 1);
    measure(nm, nb);
    chk("R8 length", nm, FULL_LEN);
  endtask

  task automatic t_wdt_sleep();
    pulse_clr_wdt();
    @(negedge clk) begin sleeping = 1'b1; wdt_timeout = 1'b1; end
    @(negedge clk) wdt_timeout = 1'b0;
    quiet_reset("R9 no reset", 5);
    chk_flags("R9", 0, 0);
    @(negedge clk) sleeping = 1'b0;
  endtask

  task automatic t_pin_glitch();
    @(negedge clk) ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    quiet_reset("R6 short pulse ignored", 8);
  endtask

  task automatic t_pin_run();
    int nm, nb;
    pulse_sleep_enter();
    @(negedge clk) ext_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 pin reset", int'(chip_reset), 1);
    chk_flags("R7 running", 1, 0);
    ext_rst_n = 1'b1;
    @(negedge clk);
    measure(nm, nb);
    chk("R3 after pin", nm, FULL_LEN);
  endtask

  task automatic t_pin_sleep();
    int nm, nb;
    pulse_clr_wdt();
    @(negedge clk) begin sleeping = 1'b1; ext_rst_n = 1'b0; end
    repeat (6) @(negedge clk);
    chk("R7 asleep reset", int'(chip_reset), 1);
    chk_flags("R7 asleep", 1, 0);
    ext_rst_n = 1'b1;
    sleeping = 1'b0;
    @(negedge clk);
    measure(nm, nb);
  endtask

  task automatic t_bor(input logic cfg, input logic sw, input string req);
    int nm, nb;
    pulse_sleep_enter();
    @(negedge clk) begin bor_cfg_en = cfg; bor_sw_en = sw; bor_detect = 1'b1; end
    @(negedge clk) bor_detect = 1'b0;
    if (cfg || sw) begin
      chk({req, " reset"}, int'(chip_reset), 1);
      chk_flags(req, 1, 1);
      measure(nm, nb);
    end else begin
      quiet_reset({req, " disabled no reset"}, 5);
      chk_flags({req, " disabled"}, 1, 0);
    end
    bor_cfg_en = 1'b0;
    bor_sw_en  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_por();
    t_restart(1000, "R5 first stage");
    t_restart(2600, "R5 second stage");
    t_clr_wdt();
    t_wdt_run();
    t_wdt_sleep();
    t_pin_glitch();
    t_pin_run();
    t_pin_sleep();
    t_bor(1'b1, 1'b0, "R10 cfg");
    t_bor(1'b0, 1'b1, "R10 sw");
    t_bor(1'b0, 1'b0, "R10 off");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule